// File: doc/BRIEF.md
# Priority-Threshold Buffer Admission Control

This block sits beside the shared packet memory of a central-memory switch. It decides whether each packet that arrives on an input port is taken into the memory or answered with a retry. The decision depends on the packet's priority, its byte length and the number of free bytes left in the shared pool. The block keeps the pool's free-byte count current as packets are admitted and as their storage is released. The data memory and the link protocol are outside the block.

Every input port keeps one buffer-sized reservation (maximum payload plus header, 268 bytes by default) taken out of the pool. A packet that arrives on a port holding its reservation is stored in it, whatever the pool's state. The port then takes a new reservation from the pool as soon as enough space is free. This guarantees that each port can always move one packet, so one port cannot starve the others and the switch cannot deadlock on full memory. Without a reservation, a priority-0 packet needs a large free margin (1000 bytes by default). Higher priorities only need room for the packet itself. A response packet counts one priority level above the priority it carries.

The controller has two states. After reset it is in `ST_RESERVE`, where it takes one reservation per cycle in ascending port order and retries every request. After the reservation for the last port is taken, it moves to `ST_SERVE` and stays there until the next reset. Within one cycle, all events are applied in a fixed order to one running free count: releases first, then arrivals from port 0 upward, then reservation re-grabs from port 0 upward.

Top module: `adm_admission_ctl`

## Requirements
- R1: While reset is asserted, `free_bytes` equals POOL_BYTES and no answers are raised. After reset, the block spends NPORTS cycles in ST_RESERVE, taking 268 bytes per cycle for ports 0, 1, ... in turn, and then enters ST_SERVE and stays there until the next reset.
- R2: Every valid request seen in a ST_RESERVE cycle is retried.
- R3: A request whose length is 0 or above 268 bytes is retried and changes no state.
- R4: A legal request on a port that holds its reservation is accepted regardless of the free count. The port gives up its reservation, and the free count rises by 268 minus the length.
- R5: A legal request of effective priority 0 on a port without its reservation is accepted only if the running free count is at least 1000. On acceptance, the free count falls by the length.
- R6: A legal request of effective priority 1, 2 or 3 on a port without its reservation is accepted only if the running free count is at least its length. On acceptance, the free count falls by the length.
- R7: With the response flag set, the effective priority is the carried priority plus one, held at 3. A priority-0 response is therefore judged as priority 1.
- R8: In one cycle, releases are applied first, then arrivals in ascending port order, then re-grabs in ascending port order. Each step sees the running free count left by the steps before it.
- R9: In ST_SERVE, a port without its reservation takes 268 bytes back from the pool in every cycle where the running free count is at least 268.
- R10: A release whose length is at most the port's occupied bytes returns that many bytes to the pool. A larger release changes nothing and raises `rel_err` for that port in the next cycle. `rel_err` is low otherwise.
- R11: The free count, plus all occupied bytes, plus 268 for every held reservation, always equals POOL_BYTES. The free count never exceeds POOL_BYTES.
- R12: Each valid request is answered in the following cycle by exactly one of `acc` or `rty`. Neither is raised without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NPORTS | Packet arrival request per port |
| req_prio | input | NPORTS x 2 | Carried priority per port (0 lowest, 3 highest) |
| req_resp | input | NPORTS | Packet is a response; raises its priority by one |
| req_len | input | NPORTS x LEN_W | Packet length in bytes, header included |
| rel_valid | input | NPORTS | Release of stored bytes per port |
| rel_len | input | NPORTS x LEN_W | Number of bytes released |
| acc | output | NPORTS | Request of the previous cycle accepted |
| rty | output | NPORTS | Request of the previous cycle retried |
| rel_err | output | NPORTS | Release of the previous cycle exceeded the port's occupancy |
| free_bytes | output | FREE_W | Free bytes in the shared pool |

## Verification
The bench uses a small pool of 3000 bytes. After the reservations are taken, this leaves 1928 free bytes, so the 1000-byte low-priority margin is crossed quickly. The pool is driven through alternating phases. Arrival-heavy phases with no releases drain the pool until reservations cannot be re-grabbed. This separates the reservation path from the two threshold paths and shows the priority-0 margin against the plain fit rule. Mixed phases put releases, arrivals and re-grabs on several ports in the same cycle, which exposes any break in the fixed port order. Release-heavy phases include oversized releases to tell error releases apart from legal ones. Illegal lengths, priority-0 responses and a mid-run reset are mixed into all of these phases.

// File: rtl/adm_pkg.sv
package adm_pkg;

    localparam int PRIO_W   = 2;
    localparam int PRIO_TOP = 3;

    typedef enum logic {
        ST_RESERVE,
        ST_SERVE
    } adm_state_e;

    // Responses are judged one level above the priority they carry, held at the top level.
    function automatic logic [PRIO_W-1:0] effective_prio(
        input logic [PRIO_W-1:0] carried,
        input logic              is_resp
    );
        if (is_resp && (carried != PRIO_W'(PRIO_TOP)))
            return carried + 1'b1;
        return carried;
    endfunction

endpackage

// File: rtl/adm_req_class.sv
module adm_req_class
    import adm_pkg::*;
#(
    parameter int SLOT_BYTES = 268,
    parameter int THR_LOW    = 1000,
    parameter int THR_HIGH   = 0,
    parameter int LEN_W      = 9,
    parameter int FREE_W     = 15
) (
    input  logic [PRIO_W-1:0] prio,
    input  logic              is_resp,
    input  logic [LEN_W-1:0]  len,
    output logic              len_ok,
    output logic [FREE_W-1:0] need
);

    logic [PRIO_W-1:0] eff;
    logic [FREE_W-1:0] thr;
    logic [FREE_W-1:0] len_w;

    always_comb begin
        eff    = effective_prio(prio, is_resp);
        thr    = (eff == '0) ? FREE_W'(THR_LOW) : FREE_W'(THR_HIGH);
        len_w  = FREE_W'(len);
        len_ok = (len != '0) && (len_w <= FREE_W'(SLOT_BYTES));
        need   = (thr > len_w) ? thr : len_w;
    end

endmodule

// File: rtl/adm_pool_ledger.sv
module adm_pool_ledger #(
    parameter int NPORTS     = 4,
    parameter int POOL_BYTES = 16384,
    parameter int SLOT_BYTES = 268,
    parameter int LEN_W      = 9,
    parameter int FREE_W     = 15,
    parameter int IDX_W      = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           grab_en,
    input  logic [IDX_W-1:0]               grab_idx,
    input  logic                           serve_en,
    input  logic [NPORTS-1:0]              req_valid,
    input  logic [NPORTS-1:0][LEN_W-1:0]   req_len,
    input  logic [NPORTS-1:0]              len_ok,
    input  logic [NPORTS-1:0][FREE_W-1:0]  need,
    input  logic [NPORTS-1:0]              rel_valid,
    input  logic [NPORTS-1:0][LEN_W-1:0]   rel_len,
    output logic [NPORTS-1:0]              acc_n,
    output logic [NPORTS-1:0]              rty_n,
    output logic [NPORTS-1:0]              err_n,
    output logic [FREE_W-1:0]              free_q,
    output logic [NPORTS-1:0][FREE_W-1:0]  occ_q,
    output logic [NPORTS-1:0]              resv_q
);

    typedef logic [FREE_W:0] run_t;

    run_t                          f;
    logic [NPORTS-1:0][FREE_W-1:0] o;
    logic [NPORTS-1:0]             r;

    // Event order within one cycle: releases, arrivals, re-grabs.
    always_comb begin
        f     = run_t'(free_q);
        o     = occ_q;
        r     = resv_q;
        acc_n = '0;
        rty_n = '0;
        err_n = '0;

        for (int p = 0; p < NPORTS; p++) begin
            if (rel_valid[p]) begin
                if (FREE_W'(rel_len[p]) > o[p]) begin
                    err_n[p] = 1'b1;
                end else begin
                    o[p] = o[p] - FREE_W'(rel_len[p]);
                    f    = f + run_t'(rel_len[p]);
                end
            end
        end

        if (grab_en) begin
            f           = f - run_t'(SLOT_BYTES);
            r[grab_idx] = 1'b1;
        end

        for (int p = 0; p < NPORTS; p++) begin
            if (req_valid[p]) begin
                if (!serve_en || !len_ok[p]) begin
                    rty_n[p] = 1'b1;
                end else if (r[p]) begin
                    acc_n[p] = 1'b1;
                    r[p]     = 1'b0;
                    o[p]     = o[p] + FREE_W'(req_len[p]);
                    f        = f + run_t'(SLOT_BYTES) - run_t'(req_len[p]);
                end else if (f >= run_t'(need[p])) begin
                    acc_n[p] = 1'b1;
                    o[p]     = o[p] + FREE_W'(req_len[p]);
                    f        = f - run_t'(req_len[p]);
                end else begin
                    rty_n[p] = 1'b1;
                end
            end
        end

        if (serve_en) begin
            for (int p = 0; p < NPORTS; p++) begin
                if (!r[p] && (f >= run_t'(SLOT_BYTES))) begin
                    r[p] = 1'b1;
                    f    = f - run_t'(SLOT_BYTES);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q <= FREE_W'(POOL_BYTES);
            occ_q  <= '0;
            resv_q <= '0;
        end else begin
            free_q <= f[FREE_W-1:0];
            occ_q  <= o;
            resv_q <= r;
        end
    end

endmodule

// File: rtl/adm_admission_ctl.sv
module adm_admission_ctl
    import adm_pkg::*;
#(
    parameter int NPORTS      = 4,
    parameter int POOL_BYTES  = 16384,
    parameter int MAX_PAYLOAD = 256,
    parameter int HDR_BYTES   = 12,
    parameter int THR_LOW     = 1000,
    parameter int THR_HIGH    = 0,
    parameter int LEN_W       = $clog2(MAX_PAYLOAD + HDR_BYTES + 1),
    parameter int FREE_W      = $clog2(POOL_BYTES + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NPORTS-1:0]             req_valid,
    input  logic [NPORTS-1:0][PRIO_W-1:0] req_prio,
    input  logic [NPORTS-1:0]             req_resp,
    input  logic [NPORTS-1:0][LEN_W-1:0]  req_len,
    input  logic [NPORTS-1:0]             rel_valid,
    input  logic [NPORTS-1:0][LEN_W-1:0]  rel_len,
    output logic [NPORTS-1:0]             acc,
    output logic [NPORTS-1:0]             rty,
    output logic [NPORTS-1:0]             rel_err,
    output logic [FREE_W-1:0]             free_bytes
);

    localparam int SLOT_BYTES = MAX_PAYLOAD + HDR_BYTES;
    localparam int IDX_W      = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    adm_state_e                    state_q;
    adm_state_e                    state_d;
    logic [IDX_W-1:0]              idx_q;
    logic                          in_reserve;
    logic [NPORTS-1:0]             len_ok;
    logic [NPORTS-1:0][FREE_W-1:0] need;
    logic [NPORTS-1:0]             acc_n;
    logic [NPORTS-1:0]             rty_n;
    logic [NPORTS-1:0]             err_n;
    logic [NPORTS-1:0][FREE_W-1:0] occ_w;
    logic [NPORTS-1:0]             resv_w;

    // Next-state logic: ST_RESERVE takes one reservation per cycle, then ST_SERVE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESERVE: if (idx_q == IDX_W'(NPORTS - 1)) state_d = ST_SERVE;
            ST_SERVE:   state_d = ST_SERVE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RESERVE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RESERVE) idx_q <= idx_q + 1'b1;
        end
    end

    assign in_reserve = (state_q == ST_RESERVE);

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_class
            adm_req_class #(
                .SLOT_BYTES (SLOT_BYTES),
                .THR_LOW    (THR_LOW),
                .THR_HIGH   (THR_HIGH),
                .LEN_W      (LEN_W),
                .FREE_W     (FREE_W)
            ) class_i (
                .prio    (req_prio[p]),
                .is_resp (req_resp[p]),
                .len     (req_len[p]),
                .len_ok  (len_ok[p]),
                .need    (need[p])
            );
        end
    endgenerate

    adm_pool_ledger #(
        .NPORTS     (NPORTS),
        .POOL_BYTES (POOL_BYTES),
        .SLOT_BYTES (SLOT_BYTES),
        .LEN_W      (LEN_W),
        .FREE_W     (FREE_W),
        .IDX_W      (IDX_W)
    ) ledger_i (
        .clk       (clk),
        .rst       (rst),
        .grab_en   (in_reserve),
        .grab_idx  (idx_q),
        .serve_en  (!in_reserve),
        .req_valid (req_valid),
        .req_len   (req_len),
        .len_ok    (len_ok),
        .need      (need),
        .rel_valid (rel_valid),
        .rel_len   (rel_len),
        .acc_n     (acc_n),
        .rty_n     (rty_n),
        .err_n     (err_n),
        .free_q    (free_bytes),
        .occ_q     (occ_w),
        .resv_q    (resv_w)
    );

    // Output register.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            rty     <= '0;
            rel_err <= '0;
        end else begin
            acc     <= acc_n;
            rty     <= rty_n;
            rel_err <= err_n;
        end
    end

endmodule

// File: rtl/adm_admission_chk.sv
module adm_admission_chk #(
    parameter int NPORTS     = 4,
    parameter int POOL_BYTES = 16384,
    parameter int SLOT_BYTES = 268,
    parameter int LEN_W      = 9,
    parameter int FREE_W     = 15
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_reserve,
    input  logic [NPORTS-1:0]             req_valid,
    input  logic [NPORTS-1:0][LEN_W-1:0]  req_len,
    input  logic [NPORTS-1:0]             rel_valid,
    input  logic [NPORTS-1:0][LEN_W-1:0]  rel_len,
    input  logic [NPORTS-1:0]             acc,
    input  logic [NPORTS-1:0]             rty,
    input  logic [NPORTS-1:0]             rel_err,
    input  logic [FREE_W-1:0]             free_bytes,
    input  logic [NPORTS-1:0][FREE_W-1:0] occ,
    input  logic [NPORTS-1:0]             resv
);

    int total;

    always_comb begin
        total = int'(free_bytes);
        for (int p = 0; p < NPORTS; p++) begin
            total = total + int'(occ[p]);
            if (resv[p]) total = total + SLOT_BYTES;
        end
    end

    a_r11_conserve: assert property (@(posedge clk) disable iff (rst)
        total == POOL_BYTES);

    a_r11_bounded: assert property (@(posedge clk) disable iff (rst)
        int'(free_bytes) <= POOL_BYTES);

    a_r1_serve_holds: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_reserve)) |-> !in_reserve);

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_port
            a_r12_one_answer: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(req_valid[p])) |-> (acc[p] ^ rty[p]));

            a_r12_no_spurious: assert property (@(posedge clk) disable iff (rst)
                !$past(req_valid[p]) |-> !(acc[p] || rty[p]));

            a_r2_reserve_retry: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(in_reserve && req_valid[p])) |-> rty[p]);

            a_r3_bad_len: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(req_valid[p] &&
                    ((req_len[p] == '0) || (int'(req_len[p]) > SLOT_BYTES)))) |-> rty[p]);

            a_r4_resv_accept: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(!in_reserve && req_valid[p] && resv[p] &&
                    (req_len[p] != '0) && (int'(req_len[p]) <= SLOT_BYTES))) |-> acc[p]);

            a_r10_err_raised: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(rel_valid[p] && (int'(rel_len[p]) > int'(occ[p]))))
                    |-> rel_err[p]);

            a_r10_err_quiet: assert property (@(posedge clk) disable iff (rst)
                !$past(rel_valid[p]) |-> !rel_err[p]);
        end
    endgenerate

endmodule

bind adm_admission_ctl adm_admission_chk #(
    .NPORTS     (NPORTS),
    .POOL_BYTES (POOL_BYTES),
    .SLOT_BYTES (MAX_PAYLOAD + HDR_BYTES),
    .LEN_W      (LEN_W),
    .FREE_W     (FREE_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_reserve (in_reserve),
    .req_valid  (req_valid),
    .req_len    (req_len),
    .rel_valid  (rel_valid),
    .rel_len    (rel_len),
    .acc        (acc),
    .rty        (rty),
    .rel_err    (rel_err),
    .free_bytes (free_bytes),
    .occ        (occ_w),
    .resv       (resv_w)
);

// File: tb/adm_admission_ctl_tb.sv
module adm_admission_ctl_tb_top;

    localparam int N      = 4;
    localparam int POOL   = 3000;
    localparam int SLOT   = 268;
    localparam int THR0   = 1000;
    localparam int LW     = 9;
    localparam int FW     = $clog2(POOL + 1);
    localparam int WATCH  = 150000;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [N-1:0]          req_valid = '0;
    logic [N-1:0][1:0]     req_prio  = '0;
    logic [N-1:0]          req_resp  = '0;
    logic [N-1:0][LW-1:0]  req_len   = '0;
    logic [N-1:0]          rel_valid = '0;
    logic [N-1:0][LW-1:0]  rel_len   = '0;
    logic [N-1:0]          acc;
    logic [N-1:0]          rty;
    logic [N-1:0]          rel_err;
    logic [FW-1:0]         free_bytes;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference state built from the requirements.
    int    m_free;
    int    m_occ  [N];
    bit    m_resv [N];
    bit    m_serve;
    int    m_idx;
    bit    e_acc  [N];
    bit    e_rty  [N];
    bit    e_err  [N];
    string e_tag  [N];

    always #5 clk = ~clk;

    adm_admission_ctl #(
        .NPORTS     (N),
        .POOL_BYTES (POOL)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_prio   (req_prio),
        .req_resp   (req_resp),
        .req_len    (req_len),
        .rel_valid  (rel_valid),
        .rel_len    (rel_len),
        .acc        (acc),
        .rty        (rty),
        .rel_err    (rel_err),
        .free_bytes (free_bytes)
    );

    task automatic check_int(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_free  = POOL;
        m_serve = 0;
        m_idx   = 0;
        for (int p = 0; p < N; p++) begin
            m_occ[p]  = 0;
            m_resv[p] = 0;
        end
    endtask

    // One cycle of the reference: releases, grab or arrivals, re-grabs (R8).
    task automatic model_step();
        int f;
        int eff;
        int len;
        int need;
        f = m_free;
        for (int p = 0; p < N; p++) begin
            e_acc[p] = 0; e_rty[p] = 0; e_err[p] = 0; e_tag[p] = "R12";
            if (rel_valid[p]) begin
                if (int'(rel_len[p]) > m_occ[p]) e_err[p] = 1;           // R10
                else begin
                    m_occ[p] -= int'(rel_len[p]);
                    f        += int'(rel_len[p]);
                end
            end
        end
        if (!m_serve) begin                                            // R1
            m_resv[m_idx] = 1;
            f -= SLOT;
        end
        for (int p = 0; p < N; p++) begin
            if (req_valid[p]) begin
                len = int'(req_len[p]);
                eff = int'(req_prio[p]);
                if (req_resp[p] && eff < 3) eff++;                      // R7
                if (!m_serve) begin
                    e_rty[p] = 1; e_tag[p] = "R2";
                end else if (len == 0 || len > SLOT) begin
                    e_rty[p] = 1; e_tag[p] = "R3";
                end else if (m_resv[p]) begin
                    e_acc[p] = 1; e_tag[p] = "R4";
                    m_resv[p] = 0;
                    m_occ[p] += len;
                    f += SLOT - len;
                end else begin
                    need = (eff == 0) ? THR0 : len;
                    if (eff == 0) e_tag[p] = "R5";
                    else if (req_resp[p] && req_prio[p] == 2'd0) e_tag[p] = "R7";
                    else e_tag[p] = "R6";
                    if (f >= need) begin
                        e_acc[p] = 1;
                        m_occ[p] += len;
                        f -= len;
                    end else e_rty[p] = 1;
                end
            end
        end
        if (m_serve) begin
            for (int p = 0; p < N; p++) begin
                if (!m_resv[p] && f >= SLOT) begin                      // R9
                    m_resv[p] = 1;
                    f -= SLOT;
                end
            end
        end
        if (!m_serve) begin
            m_idx++;
            if (m_idx == N) m_serve = 1;
        end
        m_free = f;
    endtask

    task automatic compare_outputs();
        for (int p = 0; p < N; p++) begin
            check_int({e_tag[p], "/R12"}, $sformatf("acc[%0d]", p), int'(acc[p]), int'(e_acc[p]));
            check_int({e_tag[p], "/R12"}, $sformatf("rty[%0d]", p), int'(rty[p]), int'(e_rty[p]));
            check_int("R10", $sformatf("rel_err[%0d]", p), int'(rel_err[p]), int'(e_err[p]));
        end
        check_int("R8/R9/R11", "free_bytes", int'(free_bytes), m_free);
    endtask

    task automatic drive_random(input int pct_req, input int pct_rel);
        int sel;
        int lim;
        for (int p = 0; p < N; p++) begin
            req_valid[p] = ($urandom % 100) < pct_req;
            req_prio[p]  = 2'($urandom_range(0, 3));
            req_resp[p]  = ($urandom % 4) == 0;
            sel = $urandom % 16;
            if (sel == 0)      req_len[p] = '0;
            else if (sel == 1) req_len[p] = LW'($urandom_range(SLOT + 1, 511));
            else               req_len[p] = LW'($urandom_range(1, SLOT));
            rel_valid[p] = ($urandom % 100) < pct_rel;
            sel = $urandom % 8;
            if (sel == 0) begin
                lim = m_occ[p] + $urandom_range(1, 40);
                rel_len[p] = LW'((lim > 511) ? 511 : lim);
            end else if (m_occ[p] == 0) begin
                rel_len[p] = '0;
            end else begin
                lim = (m_occ[p] > 511) ? 511 : m_occ[p];
                rel_len[p] = LW'($urandom_range(1, lim));
            end
        end
    endtask

    task automatic run_cycles(input int n, input int pct_req, input int pct_rel);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            drive_random(pct_req, pct_rel);
            model_step();
            @(posedge clk);
            #1;
            compare_outputs();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        drive_random(80, 50);
        @(posedge clk);
        #1;
        model_reset();
        check_int("R1", "free_bytes in reset", int'(free_bytes), POOL);
        check_int("R1", "acc in reset", int'(acc), 0);
        check_int("R1", "rty in reset", int'(rty), 0);
        @(negedge clk);
        rst = 1'b0;
        // Reservation phase: requests all retried (R2), pool shrinks by one slot per cycle (R1).
        for (int c = 0; c < N; c++) begin
            if (c != 0) @(negedge clk);
            drive_random(90, 0);
            model_step();
            @(posedge clk);
            #1;
            compare_outputs();
            check_int("R1", "free after grab", int'(free_bytes), POOL - (c + 1) * SLOT);
        end
    endtask

    initial begin
        model_reset();
        repeat (2) @(posedge clk);
        do_reset();
        for (int round = 0; round < 6; round++) begin
            run_cycles(150, 90, 0);    // drain: thresholds and reservations
            run_cycles(200, 60, 30);   // mixed order within cycles
            run_cycles(150, 20, 80);   // refill with oversized releases
            if (round == 2) do_reset();
        end
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCH) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule